// File: doc/BRIEF.md
# Dot-Matrix Display Refresh Sequencer

This block keeps a 32-character, 5x7 dot-matrix vacuum fluorescent display lit by streaming pattern data into two external serial drivers without pause. The segment driver is framed by a leading start bit and latches its 35 outputs on the 36th serial clock. The digit driver is a 32-bit shift register that shifts while its enable is high and latches when the enable drops. It also has a blank input that turns every output off while keeping the stored data.

For each character position, the sequencer reads seven 5-bit row words from an asynchronous pattern memory and sends them out. It then advances a single walking 1 through the digit driver. The strobe advance and the final segment bit are placed inside a blanking window, which prevents ghosting between characters.

The slot period (`PERIOD`, at least 37 serial bit slots) is a parameter. A run-time blank length input sets how many slots at the end of each period keep blank high, which sets the display brightness. A clock-enable input `tick` paces the serial interface. Each serial bit takes two ticks, so the driver clock frequency is half the tick rate.

Top module: `vfd_mux_refresh`

## Requirements
- R1: While `rst` is high and at the first sample after it: `seg_clk`, `dig_clk`, `dig_en`, `dig_data` and `blank` are low, and `mem_addr` is `{digit 0, row 6}` = 8'h06.
- R2: Every serial bit occupies one slot of two ticks. In the first tick the clock output is low and the data is set up. In the second tick the clock is high with the data held. Only one of `seg_clk` and `dig_clk` is ever high.
- R3: The first `PERIOD-37` slots of a period are idle, with no clocks and `seg_data` low. Then `seg_clk` pulses 35 times. The first pulse carries a 1 (the start bit). Pulses 2 to 35 carry pattern bits k = 1..34, where bit k is bit `(k-1)%5` of the word at row address `6-(k-1)/5`, sent from the top row address downward, LSB first.
- R4: The next slot carries a single `dig_clk` pulse with `dig_en` high throughout the slot. `dig_data` is 1 only for digit 0 and 0 otherwise, and `seg_data` is 0 in that slot.
- R5: The final slot of the period has `dig_en` low and one more `seg_clk` pulse carrying pattern bit 35 (row 0, bit 4). This is the segment driver's 36th clock.
- R6: `blank` is high for exactly the last E slots (2*E ticks) of each period, where E is the clamped blank length. This always covers the strobe slot and the final segment slot.
- R7: E equals `blank_len` clamped to the range 2 to `PERIOD-1`. With `PERIOD`=40, a request of 0 gives 2 and a request of 63 gives 39.
- R8: Digits advance 0,1,...,31 and then return to 0 with no gap slot. `mem_addr` is `{digit[4:0], row[2:0]}`, and it reads `{digit, 6}` at the start of each period.
- R9: When `tick` is low, `seg_clk`, `dig_clk`, `dig_en` and `mem_addr` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Clock enable; one serial half-bit per tick |
| blank_len | input | 6 | Requested blank slots per digit period (clamped) |
| mem_addr | output | 8 | Pattern memory address {digit, row} |
| mem_rdata | input | 5 | Row word read asynchronously at mem_addr |
| seg_clk | output | 1 | Segment driver serial clock |
| seg_data | output | 1 | Segment driver serial data |
| dig_clk | output | 1 | Digit driver serial clock |
| dig_data | output | 1 | Digit driver serial data |
| dig_en | output | 1 | Digit driver enable (falling edge latches) |
| blank | output | 1 | Display blanking |

## Verification
The hardest cases to reach are the wrap from digit 31 back to digit 0, where a fresh 1 must enter the digit chain, and the two clamp limits of the blank length. The bench walks more than 32 full periods, so it reaches the wrap and checks `dig_data` on digit 0 a second time. It also runs whole periods with out-of-range blank requests. Further periods use ticks with idle cycles between them, so every output is shown to hold while `tick` is low.

// File: rtl/vfd_mux_pkg.sv
package vfd_mux_pkg;

    typedef enum logic [2:0] {
        SL_IDLE,
        SL_START,
        SL_DATA,
        SL_STROBE,
        SL_LAST
    } slot_kind_e;

    typedef struct packed {
        logic seg_clk;
        logic seg_data;
        logic dig_clk;
        logic dig_data;
        logic dig_en;
        logic blank;
    } drv_out_t;

    // Position of a slot inside the digit period.
    function automatic slot_kind_e classify(input int unsigned slot,
                                            input int unsigned idle,
                                            input int unsigned segbits);
        if (slot < idle)                  return SL_IDLE;
        if (slot == idle)                 return SL_START;
        if (slot < idle + segbits)        return SL_DATA;
        if (slot == idle + segbits)       return SL_STROBE;
        return SL_LAST;
    endfunction

    function automatic int unsigned clamp_span(input int unsigned req,
                                               input int unsigned lo,
                                               input int unsigned hi);
        if (req < lo) return lo;
        if (req > hi) return hi;
        return req;
    endfunction

endpackage

// File: rtl/vfd_slot_timer.sv
module vfd_slot_timer #(
    parameter int unsigned PERIOD   = 40,
    parameter int unsigned N_DIGITS = 32,
    localparam int unsigned SW = $clog2(PERIOD),
    localparam int unsigned DW = $clog2(N_DIGITS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    output logic          phase,
    output logic [SW-1:0] slot,
    output logic [DW-1:0] digit,
    output logic          slot_end,
    output logic          period_end
);

    assign slot_end   = tick && phase;
    assign period_end = slot_end && (slot == SW'(PERIOD - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= 1'b0;
            slot  <= '0;
            digit <= '0;
        end else if (tick) begin
            phase <= ~phase;
            if (phase) begin
                if (slot == SW'(PERIOD - 1)) begin
                    slot  <= '0;
                    digit <= (digit == DW'(N_DIGITS - 1)) ? '0 : digit + DW'(1);
                end else begin
                    slot <= slot + SW'(1);
                end
            end
        end
    end

    // R8
    digit_step_chk: assert property (@(posedge clk) disable iff (rst)
        (digit != $past(digit)) |-> ($past(period_end)));

    // R9
    hold_on_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(slot) && $stable(phase) && $stable(digit)));

endmodule

// File: rtl/vfd_row_serializer.sv
module vfd_row_serializer
    import vfd_mux_pkg::*;
#(
    parameter int unsigned ROWS = 7,
    parameter int unsigned COLS = 5,
    localparam int unsigned RW = $clog2(ROWS),
    localparam int unsigned CW = $clog2(COLS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            slot_end,
    input  logic            period_end,
    input  slot_kind_e      kind,
    input  logic [COLS-1:0] mem_rdata,
    output logic [RW-1:0]   row,
    output logic            seg_bit
);

    logic [CW-1:0]   col;
    logic [COLS-1:0] word_sh;
    logic            carries_data;

    assign carries_data = (kind == SL_DATA) || (kind == SL_LAST);

    // First bit of each row comes straight from memory, later bits from the shifted copy.
    always_comb begin
        if (kind == SL_START)  seg_bit = 1'b1;
        else if (col == '0)    seg_bit = mem_rdata[0];
        else                   seg_bit = word_sh[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            row     <= RW'(ROWS - 1);
            col     <= '0;
            word_sh <= '0;
        end else if (slot_end) begin
            if (period_end) begin
                row <= RW'(ROWS - 1);
                col <= '0;
            end else if (carries_data) begin
                word_sh <= (col == '0) ? (mem_rdata >> 1) : (word_sh >> 1);
                if (col == CW'(COLS - 1)) begin
                    col <= '0;
                    row <= row - RW'(1);
                end else begin
                    col <= col + CW'(1);
                end
            end
        end
    end

    // R3
    row_order_chk: assert property (@(posedge clk) disable iff (rst)
        (row != $past(row) && !$past(period_end)) |-> (row == $past(row) - RW'(1)));

endmodule

// File: rtl/vfd_blank_gen.sv
module vfd_blank_gen
    import vfd_mux_pkg::*;
#(
    parameter int unsigned PERIOD = 40,
    localparam int unsigned SW = $clog2(PERIOD)
) (
    input  logic [SW-1:0] slot,
    input  logic [SW-1:0] blank_len,
    output logic          blank
);

    int unsigned span;

    always_comb begin
        span  = clamp_span(int'(blank_len), 2, PERIOD - 1);
        blank = (int'(slot) >= (PERIOD - span));
    end

endmodule

// File: rtl/vfd_mux_refresh.sv
module vfd_mux_refresh
    import vfd_mux_pkg::*;
#(
    parameter int unsigned N_DIGITS = 32,
    parameter int unsigned ROWS     = 7,
    parameter int unsigned COLS     = 5,
    parameter int unsigned PERIOD   = 40,
    localparam int unsigned SW = $clog2(PERIOD),
    localparam int unsigned DW = $clog2(N_DIGITS),
    localparam int unsigned RW = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [SW-1:0]    blank_len,
    output logic [DW+RW-1:0] mem_addr,
    input  logic [COLS-1:0]  mem_rdata,
    output logic             seg_clk,
    output logic             seg_data,
    output logic             dig_clk,
    output logic             dig_data,
    output logic             dig_en,
    output logic             blank
);

    localparam int unsigned SEG_BITS = ROWS * COLS;
    localparam int unsigned IDLE     = PERIOD - SEG_BITS - 2;

    logic          phase;
    logic [SW-1:0] slot;
    logic [DW-1:0] digit;
    logic          slot_end;
    logic          period_end;
    logic [RW-1:0] row;
    logic          seg_bit;
    logic          blank_w;
    slot_kind_e    kind;
    drv_out_t      drv;

    vfd_slot_timer #(.PERIOD(PERIOD), .N_DIGITS(N_DIGITS)) u_timer (
        .clk(clk), .rst(rst), .tick(tick),
        .phase(phase), .slot(slot), .digit(digit),
        .slot_end(slot_end), .period_end(period_end)
    );

    assign kind = classify(int'(slot), IDLE, SEG_BITS);

    vfd_row_serializer #(.ROWS(ROWS), .COLS(COLS)) u_ser (
        .clk(clk), .rst(rst), .slot_end(slot_end), .period_end(period_end),
        .kind(kind), .mem_rdata(mem_rdata), .row(row), .seg_bit(seg_bit)
    );

    vfd_blank_gen #(.PERIOD(PERIOD)) u_blank (
        .slot(slot), .blank_len(blank_len), .blank(blank_w)
    );

    always_comb begin
        drv          = '0;
        drv.seg_clk  = phase && (kind == SL_START || kind == SL_DATA || kind == SL_LAST);
        drv.seg_data = (kind == SL_START || kind == SL_DATA || kind == SL_LAST) ? seg_bit : 1'b0;
        drv.dig_en   = (kind == SL_STROBE);
        drv.dig_clk  = phase && (kind == SL_STROBE);
        drv.dig_data = (kind == SL_STROBE) && (digit == '0);
        drv.blank    = blank_w;
    end

    assign mem_addr = {digit, row};
    assign seg_clk  = drv.seg_clk;
    assign seg_data = drv.seg_data;
    assign dig_clk  = drv.dig_clk;
    assign dig_data = drv.dig_data;
    assign dig_en   = drv.dig_en;
    assign blank    = drv.blank;

    // R2
    one_clock_chk: assert property (@(posedge clk) disable iff (rst)
        !(seg_clk && dig_clk));

    // R6
    strobe_blanked_chk: assert property (@(posedge clk) disable iff (rst)
        dig_en |-> blank);

    // R5
    latch_blanked_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(dig_en) |-> (blank && !seg_clk));

    // R9
    pins_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(seg_clk) && $stable(dig_clk) && $stable(dig_en) && $stable(mem_addr)));

endmodule

// File: tb/vfd_mux_refresh_tb.sv
module vfd_mux_refresh_tb;

    localparam int PERIOD = 40;
    localparam int IDLE   = PERIOD - 37;
    localparam int NDIG   = 32;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [5:0] blank_len = 6'd4;
    logic [7:0] mem_addr;
    logic [4:0] mem_rdata;
    logic       seg_clk, seg_data, dig_clk, dig_data, dig_en, blank;

    int n_cmp = 0;
    int n_bad = 0;
    int m_digit = 0;
    int m_slot  = 0;
    int m_phase = 0;
    int gap     = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    function automatic logic [4:0] pat(input logic [7:0] a);
        logic [7:0] v;
        v = (a * 8'd5) ^ (a >> 3) ^ 8'h0b;
        return v[4:0];
    endfunction

    assign mem_rdata = pat(mem_addr);

    vfd_mux_refresh u_dut (
        .clk(clk), .rst(rst), .tick(tick), .blank_len(blank_len),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .seg_clk(seg_clk), .seg_data(seg_data), .dig_clk(dig_clk),
        .dig_data(dig_data), .dig_en(dig_en), .blank(blank)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s digit=%0d slot=%0d phase=%0d actual=%0d expected=%0d",
                     req, m_digit, m_slot, m_phase, act, exp);
        end
    endtask

    function automatic int eff_span();
        if (blank_len < 6'd2) return 2;
        if (blank_len > 6'(PERIOD - 1)) return PERIOD - 1;
        return int'(blank_len);
    endfunction

    task automatic check_state();
        int l, n, e_sclk, e_sdat, e_dclk, e_den, e_ddat, e_blank, r, c;
        l = m_slot - IDLE;
        e_sclk = 0; e_sdat = 0; e_dclk = 0; e_den = 0; e_ddat = 0;
        if (m_slot >= IDLE) begin
            if (l == 35) begin
                e_den  = 1;
                e_dclk = m_phase;
                e_ddat = (m_digit == 0) ? 1 : 0;
            end else begin
                e_sclk = m_phase;
                if (l == 0) e_sdat = 1;
                else begin
                    n = (l == 36) ? 35 : l;
                    r = 6 - (n - 1) / 5;
                    c = (n - 1) % 5;
                    e_sdat = int'(pat({5'(m_digit), 3'(r)})[c]);
                end
            end
        end
        e_blank = (m_slot >= PERIOD - eff_span()) ? 1 : 0;
        chk((l == 36) ? "R5 seg_clk" : "R3 seg_clk", int'(seg_clk), e_sclk);
        chk((l == 36) ? "R5 seg_data" : "R3 seg_data", int'(seg_data), e_sdat);
        chk("R4 dig_clk", int'(dig_clk), e_dclk);
        chk("R4 dig_en", int'(dig_en), e_den);
        chk("R4 dig_data", int'(dig_data), e_ddat);
        chk("R6 blank", int'(blank), e_blank);
        chk("R2 single clock", int'(seg_clk && dig_clk), 0);
        if (m_slot == 0 && m_phase == 0)
            chk("R8 mem_addr", int'(mem_addr), (m_digit << 3) | 6);
    endtask

    task automatic adv();
        logic s_sc, s_dc, s_de;
        logic [7:0] s_ad;
        for (int i = 0; i < gap; i++) begin
            s_sc = seg_clk; s_dc = dig_clk; s_de = dig_en; s_ad = mem_addr;
            tick = 1'b0;
            @(negedge clk);
            chk("R9 hold", int'({seg_clk, dig_clk, dig_en, mem_addr}),
                int'({s_sc, s_dc, s_de, s_ad}));
        end
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        if (m_phase == 1) begin
            m_phase = 0;
            if (m_slot == PERIOD - 1) begin
                m_slot  = 0;
                m_digit = (m_digit + 1) % NDIG;
            end else m_slot++;
        end else m_phase = 1;
    endtask

    task automatic run_digits(input int nd, input logic [5:0] req, input int g, input string tag);
        int bcnt;
        blank_len = req;
        gap = g;
        for (int d = 0; d < nd; d++) begin
            bcnt = 0;
            for (int k = 0; k < 2 * PERIOD; k++) begin
                check_state();
                if (blank) bcnt++;
                adv();
            end
            chk(tag, bcnt, 2 * eff_span());
        end
    endtask

    task automatic t_reset();
        tick = 1'b0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        m_digit = 0; m_slot = 0; m_phase = 0;
        chk("R1 clocks", int'({seg_clk, dig_clk}), 0);
        chk("R1 enable/data", int'({dig_en, dig_data}), 0);
        chk("R1 blank", int'(blank), 0);
        chk("R1 mem_addr", int'(mem_addr), 8'h06);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after release", int'({seg_clk, dig_clk, dig_en, blank}), 0);
    endtask

    // Full frame plus wrap back to digit 0 (R8, R3, R4, R5, R6)
    task automatic t_frame();
        run_digits(NDIG + 1, 6'd6, 0, "R6 blank count");
        chk("R8 wrapped digit", m_digit, 1);
    endtask

    task automatic t_clamp_low();
        run_digits(2, 6'd0, 1, "R7 low clamp count");
    endtask

    task automatic t_clamp_high();
        run_digits(2, 6'd63, 0, "R7 high clamp count");
    endtask

    task automatic t_stall();
        run_digits(1, 6'd20, 3, "R9 stalled period count");
    endtask

    task automatic t_mid_reset();
        gap = 0;
        for (int i = 0; i < 17; i++) adv();
        t_reset();
        run_digits(1, 6'd39, 0, "R7 exact max count");
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_frame();
        t_clamp_low();
        t_clamp_high();
        t_stall();
        t_mid_reset();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

endmodule